// File: doc/BRIEF.md
# Column-Group Test Scan Controller

This block picks which group of eight neighbouring pixel columns is routed to the eight analog test outputs of a pixel matrix. The 640 columns form 80 groups of eight. The choice is held in a ring of 80 enable flip-flops, with exactly one flip-flop set. Each enable line drives the analog switches of one group, and a binary index of the active group is provided next to it.

In normal mode the ring does not move. The first group (columns 0 to 7) is watched without a break. In scan mode the controller counts line strobes, one strobe for each matrix line read. Once a whole frame of 640 lines has been read, the selection moves to the next group. After the last group it returns to the first. Each time the block enters scan mode, both the selection and the line count start again from zero. When the block leaves scan mode, the selection returns to the first group.

Top module: `scan_colgroup_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, `group_en_o` equals 1 (only bit 0 set) and `group_idx_o` equals 0.
- R2: At all times exactly one bit of `group_en_o` is high. Its bit position equals `group_idx_o`.
- R3: While `scan_mode_i` is 0, the selection stays on group 0 whatever `line_strobe_i` does.
- R4: In scan mode, each 640th counted line strobe moves the selection from group g to group g+1. The new value is visible right after the clock edge that samples that strobe. Strobes in between never change the selection.
- R5: In scan mode, the frame that ends while group 79 is selected moves the selection back to group 0.
- R6: The first cycle in which `scan_mode_i` is 1, after it was 0, restarts the line count at zero and keeps group 0. A strobe in that cycle is not counted.
- R7: On the first clock edge that samples `scan_mode_i` low after scan mode, the selection returns to group 0, from any group and any line count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_mode_i | input | 1 | 1 = scan mode, 0 = normal mode |
| line_strobe_i | input | 1 | One-cycle pulse for each matrix line read |
| group_en_o | output | 80 | One-hot enables, bit g routes columns 8g..8g+7 |
| group_idx_o | output | 7 | Binary index of the selected group |

## Verification
Every output is registered. A change of mode, or the strobe that completes a frame, shows on both outputs one clock edge after it is sampled. The bench drives inputs on the falling edge and samples on the falling edge that follows the deciding rising edge. After each stimulus it inserts one idle cycle before it compares, so each check reads a settled state. The leave-scan case and the entry-strobe case are sampled exactly one edge later, to pin down the one-cycle latency.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int DEF_NUM_COLS        = 640;
    localparam int DEF_COLS_PER_GROUP  = 8;
    localparam int DEF_LINES_PER_FRAME = 640;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_SCAN   = 1'b1
    } scan_mode_e;

endpackage

// File: rtl/scan_line_ctr.sv
module scan_line_ctr #(
    parameter int LINES = 640,
    localparam int CW   = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic count_i,
    output logic frame_done_o
);
    localparam logic [CW-1:0] LAST = CW'(LINES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        frame_done_o = 1'b0;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (count_i) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt     = '0;
                frame_done_o = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/scan_onehot_ring.sv
module scan_onehot_ring #(
    parameter int STAGES = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    output logic [STAGES-1:0] en_o
);
    logic [STAGES-1:0] ring_d, ring_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        localparam int PREV = (i == 0) ? STAGES - 1 : i - 1;
        always_comb begin
            if (clear_i)     ring_d[i] = (i == 0);
            else if (step_i) ring_d[i] = ring_q[PREV];
            else             ring_d[i] = ring_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ring_q <= STAGES'(1);
        else        ring_q <= ring_d;
    end

    assign en_o = ring_q;
endmodule

// File: rtl/scan_group_index.sv
module scan_group_index #(
    parameter int GROUPS = 80,
    localparam int IW    = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          step_i,
    output logic [IW-1:0] idx_o
);
    localparam logic [IW-1:0] LAST = IW'(GROUPS - 1);

    logic [IW-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clear_i)             idx_d = '0;
        else if (step_i) begin
            if (idx_q == LAST)   idx_d = '0;
            else                 idx_d = idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx_o = idx_q;
endmodule

// File: rtl/scan_colgroup_ctrl.sv
module scan_colgroup_ctrl #(
    parameter int NUM_COLS        = scan_pkg::DEF_NUM_COLS,
    parameter int COLS_PER_GROUP  = scan_pkg::DEF_COLS_PER_GROUP,
    parameter int LINES_PER_FRAME = scan_pkg::DEF_LINES_PER_FRAME,
    localparam int NUM_GROUPS     = NUM_COLS / COLS_PER_GROUP,
    localparam int IDX_W          = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scan_mode_i,
    input  logic                  line_strobe_i,
    output logic [NUM_GROUPS-1:0] group_en_o,
    output logic [IDX_W-1:0]      group_idx_o
);
    import scan_pkg::*;

    typedef struct packed {
        scan_mode_e mode;
    } top_state_t;

    top_state_t st_d, st_q;
    logic entering, clear_sel, count_line, frame_done;

    always_comb begin
        st_d       = st_q;
        st_d.mode  = scan_mode_i ? MODE_SCAN : MODE_NORMAL;
        entering   = scan_mode_i && (st_q.mode == MODE_NORMAL);
        clear_sel  = !scan_mode_i || entering;
        count_line = scan_mode_i && !entering && line_strobe_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_NORMAL};
        else        st_q <= st_d;
    end

    scan_line_ctr #(.LINES(LINES_PER_FRAME)) u_lines (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear_sel),
        .count_i      (count_line),
        .frame_done_o (frame_done)
    );

    scan_onehot_ring #(.STAGES(NUM_GROUPS)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_sel),
        .step_i  (frame_done),
        .en_o    (group_en_o)
    );

    scan_group_index #(.GROUPS(NUM_GROUPS)) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_sel),
        .step_i  (frame_done),
        .idx_o   (group_idx_o)
    );
endmodule

// File: rtl/scan_colgroup_chk.sv
module scan_colgroup_chk #(
    parameter int NUM_GROUPS = 80,
    parameter int IDX_W      = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scan_mode_i,
    input logic                  line_strobe_i,
    input logic [NUM_GROUPS-1:0] group_en_o,
    input logic [IDX_W-1:0]      group_idx_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_GROUPS - 1);

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(group_en_o) == 1);

    p_idx_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        group_en_o[group_idx_o] == 1'b1);

    p_normal_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_mode_i |=> group_idx_o == '0);

    p_no_strobe_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_mode_i && !line_strobe_i) |=> $stable(group_idx_o));

    p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_mode_i && group_idx_o != LAST) |=>
        (group_idx_o == $past(group_idx_o) || group_idx_o == $past(group_idx_o) + 1'b1));

    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_mode_i && group_idx_o == LAST) |=> (group_idx_o == LAST || group_idx_o == '0));

    p_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_mode_i && !$past(scan_mode_i)) |=> group_idx_o == '0);

    p_leave_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_mode_i && group_idx_o != '0) |=> group_en_o[0]);
endmodule

bind scan_colgroup_ctrl scan_colgroup_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .IDX_W      (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scan_mode_i   (scan_mode_i),
    .line_strobe_i (line_strobe_i),
    .group_en_o    (group_en_o),
    .group_idx_o   (group_idx_o)
);

// File: tb/sim_scan_colgroup_ctrl.sv
`timescale 1ns/1ps
module sim_scan_colgroup_ctrl;
    localparam int NG    = 80;
    localparam int IW    = 7;
    localparam int LINES = 640;
    localparam int NSTEP = 10;

    // table: mode, strobes, expected group after the step
    localparam int T_MODE[NSTEP] = '{0,   1,   1,   1,   1,    1,    0,  1,   1,   1};
    localparam int T_STRB[NSTEP] = '{700, 0,   639, 1,   640,  1280, 0,  0,   639, 1};
    localparam int T_EXP [NSTEP] = '{0,   0,   0,   1,   2,    4,    0,  0,   0,   1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_mode = 1'b0;
    logic strobe = 1'b0;
    logic [NG-1:0] en;
    logic [IW-1:0] idx;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    scan_colgroup_ctrl u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .scan_mode_i   (scan_mode),
        .line_strobe_i (strobe),
        .group_en_o    (en),
        .group_idx_o   (idx)
    );

    task automatic check_sel(input int exp, input string req);
        logic [NG-1:0] exp_en;
        exp_en = NG'(1) << exp;
        n_run++;
        if (idx !== IW'(exp) || en !== exp_en) begin
            n_fail++;
            $display("FAIL %s: idx=%0d en=%h expected idx=%0d en=%h", req, idx, en, exp, exp_en);
        end
    endtask

    task automatic pulse_lines(input int n);
        for (int k = 0; k < n; k++) begin
            strobe = 1'b1;
            @(negedge clk);
        end
        strobe = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_sel(0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_sel(0, "R1 after release");

        // table walk: R3 normal ignore, R6 entry, R4 advance, R7 leave
        for (int s = 0; s < NSTEP; s++) begin
            scan_mode = T_MODE[s][0];
            @(negedge clk);
            pulse_lines(T_STRB[s]);
            @(negedge clk);
            check_sel(T_EXP[s], $sformatf("R4/R3/R6/R7 table step %0d", s));
        end

        // R4: exact cycle of the advance (group 1 -> 2)
        pulse_lines(LINES - 1);
        check_sel(1, "R4 before last strobe");
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        check_sel(2, "R4 edge of last strobe");

        // R7: leave mid-frame, group 0 one edge later
        pulse_lines(100);
        scan_mode = 1'b0;
        @(negedge clk);
        check_sel(0, "R7 leave one edge");

        // R6: strobe in entry cycle not counted
        scan_mode = 1'b1;
        pulse_lines(LINES);
        check_sel(0, "R6 entry strobe ignored");
        pulse_lines(1);
        check_sel(1, "R6 count restarted");

        // R5: full wrap through group 79
        scan_mode = 1'b0;
        @(negedge clk);
        scan_mode = 1'b1;
        @(negedge clk);
        pulse_lines(LINES * (NG - 1));
        @(negedge clk);
        check_sel(NG - 1, "R5 reach last group");
        pulse_lines(LINES);
        @(negedge clk);
        check_sel(0, "R5 wrap to group 0");
        pulse_lines(LINES);
        check_sel(1, "R5 continues after wrap");

        // R1: reset in mid-scan
        rst_n = 1'b0;
        @(negedge clk);
        check_sel(0, "R1 reset mid-scan");
        scan_mode = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_sel(0, "R1 release mid-scan");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule